// File: doc/BRIEF.md
# DDR3 Power-Up Command Sequencer

This block sits on the controller side of a DDR3 memory interface and takes charge of the command pins for the short stretch between reset and normal operation. Once reset is released it raises clock enable and keeps it high. It then plays a fixed list of seven commands onto the command, bank and address outputs, with a counted run of NOOP cycles before each one:

- four mode-register writes, in the order 2, 3, 1, 0;
- a long ZQ calibration;
- a precharge of all banks;
- a single refresh.

After the refresh it keeps driving NOOPs until the refresh recovery window has run out. It then raises a registered ready flag that hands the pins to the operational controller.

The contents of the four mode registers and the length of every NOOP gap are parameters. The default gaps are one clock longer than the smallest legal spacing. In the clock where the refresh is issued, the block also pulses a strobe so that the operational controller can clear its refresh-interval counter.

The sequencer is one phase register with these named states:

| State | Command issued on leaving it | Next state |
|---|---|---|
| `PH_MR2` | mode-register write, bank 2 | `PH_MR3` |
| `PH_MR3` | mode-register write, bank 3 | `PH_MR1` |
| `PH_MR1` | mode-register write, bank 1 | `PH_MR0` |
| `PH_MR0` | mode-register write, bank 0 | `PH_ZQCL` |
| `PH_ZQCL` | long ZQ calibration | `PH_PREA` |
| `PH_PREA` | precharge of all banks | `PH_REF` |
| `PH_REF` | refresh | `PH_SETTLE` |
| `PH_SETTLE` | none (sets ready) | `PH_READY` |
| `PH_READY` | none | stays |

Each transition is taken in the clock where the gap timer reaches that state's gap length. Reset returns the phase to `PH_MR2` from any state.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst_n` is low the block drives the following, with the asynchronous reset taking effect at once even in the middle of the sequence:
  - `cmd_o` = NOOP (4'b0111);
  - `bank_o` = 0 and `addr_o` = 0;
  - `cke_o`, `ready_o` and `refresh_clr_o` = 0.

  From the first rising edge after release, `cke_o` is 1 in every cycle.
- R2: `cmd_o` is {cs_n, ras_n, cas_n, we_n}. The codes are NOOP 0111, mode-register write 0000, precharge 0010, refresh 0001 and ZQ calibration 0110. Exactly seven non-NOOP commands are issued after reset, in this order: mode-register write to bank 2, bank 3, bank 1, bank 0, then ZQ calibration, precharge, refresh. `bank_o` and `addr_o` are zero in every NOOP cycle.
- R3: Each mode-register write drives its register number on `bank_o` and the matching parameter (MR2_VAL, MR3_VAL, MR1_VAL, MR0_VAL) on `addr_o`. The last write goes to bank 0.
- R4: Before each mode-register write there are exactly GAP_MRD NOOP cycles (default 4). For the first write they are counted from the first edge after reset.
- R5: Exactly GAP_MOD NOOP cycles (default 12) follow the bank-0 write. The ZQ calibration is then issued with `addr_o` = 0x400 (bit 10 set) and `bank_o` = 0.
- R6: Exactly GAP_ZQINIT NOOP cycles (default 513) follow the ZQ calibration. The precharge is then issued with `addr_o` = 0x400 and `bank_o` = 0.
- R7: Exactly GAP_RP NOOP cycles (default 4) follow the precharge, and then the refresh is issued. `refresh_clr_o` is 1 in the refresh cycle and in no other cycle.
- R8: After the refresh there are GAP_RFC NOOP cycles (default 141) with `ready_o` low. `ready_o` rises in the next cycle.
- R9: Once `ready_o` is 1 it stays 1 and `cmd_o` stays NOOP until reset is asserted again. A new reset restarts the whole sequence from R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 4 | Command code {cs_n, ras_n, cas_n, we_n} |
| bank_o | output | BANK_W (3) | Bank address |
| addr_o | output | ADDR_W (14) | Row/column address bus |
| refresh_clr_o | output | 1 | One-cycle strobe in the refresh cycle |
| ready_o | output | 1 | Sequence complete; sticky until reset |

## Verification
The bench runs the full sequence and compares every output port in every cycle against a timeline that it computes from the gap parameters. This separates wrong gap lengths, wrong command order, wrong bank or address fields and a misplaced ready edge.

It then sweeps reset re-assertion across the cycles just before, on and just after each of the seven command slots. This exposes state, such as phase or counter values, that survives reset, or an off-by-one in the restart. Finally, a long run after ready shows whether ready stays high and the bus stays idle.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ZQC = 4'b0110,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    typedef enum logic [3:0] {
        PH_MR2    = 4'd0,
        PH_MR3    = 4'd1,
        PH_MR1    = 4'd2,
        PH_MR0    = 4'd3,
        PH_ZQCL   = 4'd4,
        PH_PREA   = 4'd5,
        PH_REF    = 4'd6,
        PH_SETTLE = 4'd7,
        PH_READY  = 4'd8
    } init_phase_e;

    // Address bit that selects "long" ZQ and "all banks" precharge
    localparam int unsigned ALL_BANKS_BIT = 10;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic init_phase_e phase_after(input init_phase_e p);
        init_phase_e n;
        unique case (p)
            PH_MR2:    n = PH_MR3;
            PH_MR3:    n = PH_MR1;
            PH_MR1:    n = PH_MR0;
            PH_MR0:    n = PH_ZQCL;
            PH_ZQCL:   n = PH_PREA;
            PH_PREA:   n = PH_REF;
            PH_REF:    n = PH_SETTLE;
            PH_SETTLE: n = PH_READY;
            default:   n = PH_READY;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ddr3_init_gap_timer.sv
module ddr3_init_gap_timer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] target,
    output logic             expired
);

    logic [CNT_W-1:0] idle_q;

    // Counts NOOP clocks since the last issued command; saturates at all-ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (restart) begin
            idle_q <= '0;
        end else if (idle_q != {CNT_W{1'b1}}) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign expired = (idle_q >= target);

endmodule

// File: rtl/ddr3_init_step_table.sv
module ddr3_init_step_table
    import ddr3_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned BANK_W     = 3,
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned MR0_VAL    = 32'h0000_0520,
    parameter int unsigned MR1_VAL    = 32'h0000_0044,
    parameter int unsigned MR2_VAL    = 32'h0000_0008,
    parameter int unsigned MR3_VAL    = 32'h0000_0000,
    parameter int unsigned GAP_MRD    = 4,
    parameter int unsigned GAP_MOD    = 12,
    parameter int unsigned GAP_ZQINIT = 513,
    parameter int unsigned GAP_RP     = 4,
    parameter int unsigned GAP_RFC    = 141
) (
    input  init_phase_e       phase,
    output ddr_cmd_e          step_cmd,
    output logic [BANK_W-1:0] step_bank,
    output logic [ADDR_W-1:0] step_addr,
    output logic [CNT_W-1:0]  step_gap
);

    localparam int unsigned MR_COUNT = 4;

    // Mode-register images indexed by register number
    logic [ADDR_W-1:0] mr_image [MR_COUNT];

    for (genvar g = 0; g < MR_COUNT; g++) begin : g_mr
        localparam int unsigned RAW = (g == 0) ? MR0_VAL :
                                      (g == 1) ? MR1_VAL :
                                      (g == 2) ? MR2_VAL : MR3_VAL;
        assign mr_image[g] = ADDR_W'(RAW);
    end

    logic [ADDR_W-1:0] all_banks_addr;
    always_comb begin
        all_banks_addr = '0;
        all_banks_addr[ALL_BANKS_BIT] = 1'b1;
    end

    always_comb begin
        step_cmd  = CMD_NOP;
        step_bank = '0;
        step_addr = '0;
        step_gap  = CNT_W'(GAP_MRD);
        unique case (phase)
            PH_MR2: begin
                step_cmd  = CMD_MRS;
                step_bank = BANK_W'(2);
                step_addr = mr_image[2];
                step_gap  = CNT_W'(GAP_MRD);
            end
            PH_MR3: begin
                step_cmd  = CMD_MRS;
                step_bank = BANK_W'(3);
                step_addr = mr_image[3];
                step_gap  = CNT_W'(GAP_MRD);
            end
            PH_MR1: begin
                step_cmd  = CMD_MRS;
                step_bank = BANK_W'(1);
                step_addr = mr_image[1];
                step_gap  = CNT_W'(GAP_MRD);
            end
            PH_MR0: begin
                step_cmd  = CMD_MRS;
                step_bank = '0;
                step_addr = mr_image[0];
                step_gap  = CNT_W'(GAP_MRD);
            end
            PH_ZQCL: begin
                step_cmd  = CMD_ZQC;
                step_addr = all_banks_addr;
                step_gap  = CNT_W'(GAP_MOD);
            end
            PH_PREA: begin
                step_cmd  = CMD_PRE;
                step_addr = all_banks_addr;
                step_gap  = CNT_W'(GAP_ZQINIT);
            end
            PH_REF: begin
                step_cmd  = CMD_REF;
                step_gap  = CNT_W'(GAP_RP);
            end
            PH_SETTLE: begin
                step_cmd  = CMD_NOP;
                step_gap  = CNT_W'(GAP_RFC);
            end
            default: begin
                step_cmd  = CMD_NOP;
                step_gap  = '0;
            end
        endcase
    end

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
    import ddr3_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 14,
    parameter int unsigned BANK_W     = 3,
    parameter int unsigned MR0_VAL    = 32'h0000_0520,
    parameter int unsigned MR1_VAL    = 32'h0000_0044,
    parameter int unsigned MR2_VAL    = 32'h0000_0008,
    parameter int unsigned MR3_VAL    = 32'h0000_0000,
    parameter int unsigned GAP_MRD    = 4,
    parameter int unsigned GAP_MOD    = 12,
    parameter int unsigned GAP_ZQINIT = 513,
    parameter int unsigned GAP_RP     = 4,
    parameter int unsigned GAP_RFC    = 141
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke_o,
    output logic [3:0]        cmd_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              refresh_clr_o,
    output logic              ready_o
);

    localparam int unsigned MAX_GAP =
        umax(umax(umax(GAP_MRD, GAP_MOD), umax(GAP_ZQINIT, GAP_RP)), GAP_RFC);
    localparam int unsigned CNT_W = $clog2(MAX_GAP + 1) + 1;

    init_phase_e       phase_q, phase_d;
    ddr_cmd_e          step_cmd;
    logic [BANK_W-1:0] step_bank;
    logic [ADDR_W-1:0] step_addr;
    logic [CNT_W-1:0]  step_gap;
    logic              gap_done;
    logic              fire;

    ddr3_init_step_table #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CNT_W(CNT_W),
        .MR0_VAL(MR0_VAL), .MR1_VAL(MR1_VAL), .MR2_VAL(MR2_VAL), .MR3_VAL(MR3_VAL),
        .GAP_MRD(GAP_MRD), .GAP_MOD(GAP_MOD), .GAP_ZQINIT(GAP_ZQINIT),
        .GAP_RP(GAP_RP), .GAP_RFC(GAP_RFC)
    ) u_table (
        .phase     (phase_q),
        .step_cmd  (step_cmd),
        .step_bank (step_bank),
        .step_addr (step_addr),
        .step_gap  (step_gap)
    );

    ddr3_init_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (fire),
        .target  (step_gap),
        .expired (gap_done)
    );

    assign fire = gap_done && (phase_q != PH_READY);

    always_comb begin
        phase_d = fire ? phase_after(phase_q) : phase_q;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_MR2;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Registered pin drivers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_o         <= 1'b0;
            cmd_o         <= CMD_NOP;
            bank_o        <= '0;
            addr_o        <= '0;
            refresh_clr_o <= 1'b0;
            ready_o       <= 1'b0;
        end else begin
            cke_o         <= 1'b1;
            refresh_clr_o <= fire && (phase_q == PH_REF);
            ready_o       <= ready_o || (fire && (phase_q == PH_SETTLE));
            if (fire) begin
                cmd_o  <= step_cmd;
                bank_o <= step_bank;
                addr_o <= step_addr;
            end else begin
                cmd_o  <= CMD_NOP;
                bank_o <= '0;
                addr_o <= '0;
            end
        end
    end

endmodule

// File: rtl/ddr3_init_seq_chk.sv
module ddr3_init_seq_chk
    import ddr3_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_o,
    input logic [3:0]        cmd_o,
    input logic [BANK_W-1:0] bank_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              refresh_clr_o,
    input logic              ready_o
);

    // Smallest legal spacings (strictly greater than these)
    localparam int unsigned MIN_MRD  = 3;
    localparam int unsigned MIN_MOD  = 11;
    localparam int unsigned MIN_ZQ   = 512;
    localparam int unsigned MIN_RP   = 3;
    localparam int unsigned MIN_RFC  = 140;

    logic              started;
    logic [15:0]       idle_cnt;
    logic [15:0]       since_ref;
    logic              ref_seen;
    logic [BANK_W-1:0] last_mr_bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started      <= 1'b0;
            idle_cnt     <= '0;
            since_ref    <= '0;
            ref_seen     <= 1'b0;
            last_mr_bank <= '1;
        end else begin
            started <= 1'b1;
            if (cmd_o != CMD_NOP) idle_cnt <= '0;
            else if (idle_cnt != 16'hFFFF) idle_cnt <= idle_cnt + 1'b1;
            if (cmd_o == CMD_REF) begin
                since_ref <= '0;
                ref_seen  <= 1'b1;
            end else if (since_ref != 16'hFFFF) begin
                since_ref <= since_ref + 1'b1;
            end
            if (cmd_o == CMD_MRS) last_mr_bank <= bank_o;
        end
    end

    assert_cke_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> cke_o);

    assert_mr_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_MRS) |-> (idle_cnt > 16'(MIN_MRD)));

    assert_last_mr_bank0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ZQC) |-> (last_mr_bank == '0));

    assert_zq_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ZQC) |-> (addr_o == ADDR_W'(32'h400) && bank_o == '0
                                && idle_cnt > 16'(MIN_MOD)));

    assert_pre_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRE) |-> (addr_o == ADDR_W'(32'h400) && idle_cnt > 16'(MIN_ZQ)));

    assert_ref_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF) |-> (idle_cnt > 16'(MIN_RP)));

    assert_clr_with_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_clr_o |-> (cmd_o == CMD_REF));

    assert_settle_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (ref_seen && since_ref > 16'(MIN_RFC)));

    assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (cmd_o == CMD_NOP));

    assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> ready_o);

endmodule

bind ddr3_init_seq ddr3_init_seq_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cke_o         (cke_o),
    .cmd_o         (cmd_o),
    .bank_o        (bank_o),
    .addr_o        (addr_o),
    .refresh_clr_o (refresh_clr_o),
    .ready_o       (ready_o)
);

// File: tb/ddr3_init_seq_test.sv
module ddr3_init_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 14;
    localparam int BANK_W = 3;
    localparam int MR0 = 32'h1D70;
    localparam int MR1 = 32'h0046;
    localparam int MR2 = 32'h0218;
    localparam int MR3 = 32'h0004;
    localparam int G_MRD = 4;
    localparam int G_MOD = 12;
    localparam int G_ZQ  = 513;
    localparam int G_RP  = 4;
    localparam int G_RFC = 141;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_MRS = 4'b0000;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_ZQC = 4'b0110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_o, refresh_clr_o, ready_o;
    logic [3:0] cmd_o;
    logic [BANK_W-1:0] bank_o;
    logic [ADDR_W-1:0] addr_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr3_init_seq #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .MR0_VAL(MR0), .MR1_VAL(MR1), .MR2_VAL(MR2), .MR3_VAL(MR3),
        .GAP_MRD(G_MRD), .GAP_MOD(G_MOD), .GAP_ZQINIT(G_ZQ),
        .GAP_RP(G_RP), .GAP_RFC(G_RFC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cke_o(cke_o), .cmd_o(cmd_o),
        .bank_o(bank_o), .addr_o(addr_o),
        .refresh_clr_o(refresh_clr_o), .ready_o(ready_o)
    );

    // Expected command timeline (cycle index n = 1 is the first edge after release)
    int slot   [7];
    int gap_of [7];
    logic [3:0] cmd_of [7];
    int bank_of[7];
    int addr_of[7];
    string tag_of[7];
    int ready_n;

    task automatic check(input string tag, input int actual, input int expected, input string what);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, actual, expected, $time);
        end
    endtask

    task automatic check_reset_state(input string tag);
        check(tag, int'(cmd_o), int'(C_NOP), "cmd in reset");
        check(tag, int'(bank_o), 0, "bank in reset");
        check(tag, int'(addr_o), 0, "addr in reset");
        check(tag, int'(cke_o), 0, "cke in reset");
        check(tag, int'(ready_o), 0, "ready in reset");
        check(tag, int'(refresh_clr_o), 0, "refresh_clr in reset");
    endtask

    task automatic check_cycle(input int n);
        logic [3:0] ec;
        int eb, ea, sj;
        string tg;
        ec = C_NOP; eb = 0; ea = 0; sj = -1;
        tg = (n > ready_n) ? "R9" : "R2";
        for (int j = 0; j < 7; j++) begin
            if (n == slot[j]) begin
                ec = cmd_of[j]; eb = bank_of[j]; ea = addr_of[j]; sj = j;
                tg = tag_of[j];
            end
        end
        check("R1", int'(cke_o), 1, "cke");
        check(tg, int'(cmd_o), int'(ec), $sformatf("cmd cycle %0d", n));
        check((sj >= 0 && sj < 4) ? "R3" : tg, int'(bank_o), eb, $sformatf("bank cycle %0d", n));
        check((sj >= 0 && sj < 4) ? "R3" : tg, int'(addr_o), ea, $sformatf("addr cycle %0d", n));
        check("R7", int'(refresh_clr_o), (n == slot[6]) ? 1 : 0, $sformatf("refresh_clr cycle %0d", n));
        check((n > ready_n) ? "R9" : "R8", int'(ready_o), (n >= ready_n) ? 1 : 0,
              $sformatf("ready cycle %0d", n));
    endtask

    // Reset, release, then check cycles 1..limit; a later call re-asserts reset mid-run
    task automatic run_seq(input int limit);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("R1");
        repeat (2) @(negedge clk);
        check_reset_state("R9");
        rst_n = 1'b1;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            check_cycle(n);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        gap_of  = '{G_MRD, G_MRD, G_MRD, G_MRD, G_MOD, G_ZQ, G_RP};
        cmd_of  = '{C_MRS, C_MRS, C_MRS, C_MRS, C_ZQC, C_PRE, C_REF};
        bank_of = '{2, 3, 1, 0, 0, 0, 0};
        addr_of = '{MR2, MR3, MR1, MR0, 32'h400, 32'h400, 0};
        tag_of  = '{"R4", "R4", "R4", "R4", "R5", "R6", "R7"};
        begin
            int acc;
            acc = 0;
            for (int j = 0; j < 7; j++) begin
                acc = acc + gap_of[j] + 1;
                slot[j] = acc;
            end
            ready_n = slot[6] + G_RFC + 1;
        end

        // Sweep reset re-assertion around every command slot
        for (int j = 0; j < 7; j++) begin
            for (int d = -1; d <= 1; d++) begin
                run_seq(slot[j] + d);
            end
        end
        // Around the ready edge
        run_seq(ready_n - 1);
        run_seq(ready_n);
        // Full run and long idle afterwards
        run_seq(ready_n + 400);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule